// File: doc/BRIEF.md
# Warp Lane Issue Sequencer

This block takes one instruction for a warp of 32 thread slots and spreads it over a smaller set of execution lanes across several clock cycles. While a warp is in flight it presents one slice per cycle. For each lane the slice carries an enable and the index of the thread that lane serves. It also carries a warp identifier per lane group and a final-slice flag, so that downstream collectors can gather the results. The arithmetic, register file access and warp selection sit outside this block, and the lanes are treated as plain sinks.

The lanes form two groups of 16. A 2-bit class code picks the lanes in use and the number of cycles per warp:

- Narrow class: 8 lanes of group 0, 4 cycles.
- Special-function class: a 4-lane shared unit on group 0, 8 cycles.
- Dual class: two separate warps, one on each 16-lane group, both done in 2 cycles.
- Fused double-precision class: 8 lanes from each group form one 16-lane unit running a single warp in 2 cycles.

A 32-bit active-thread mask comes with each warp. It can force lane enables low, but it never changes the cycle count.

Top module: `simt_warp_issue`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is high and `grp_valid`, `slice_en` and `done` are all low.
- R2: An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its first slice appears in the next cycle. `in_ready` stays low from that slice through the final one.
- R3: Class code 0 (narrow) runs 4 slices on lanes 0..7 of group 0. In slice k, lane j serves thread k*8+j.
- R4: Class code 1 (special-function) runs 8 slices on lanes 0..3 of group 0. In slice k, lane j serves thread k*4+j.
- R5: Class code 2 (dual) runs 2 slices. In slice k, lane j of each group serves thread k*16+j. Group 0 carries the first warp's id and mask. Group 1 carries the second warp's id and mask.
- R6: In dual class with `in_has_b` low, `grp_valid[1]` and all group 1 enables stay low, and the first warp still completes in 2 slices.
- R7: Class code 3 (fused) runs 2 slices. Lanes 0..7 of group g serve thread k*16+g*8+j. Both groups are valid and both carry the first warp's id.
- R8: A lane's enable is high only when that lane is in use and bit t of the governing mask is 1, where t is the lane's thread index. The mask never alters the number of slices.
- R9: Lanes not in use show enable 0 and thread index 0. Lane j of group g sits at `slice_en[g*16+j]` and `slice_tid[(g*16+j)*5 +: 5]`.
- R10: `slice_last` and `done` are high only in the final slice of a warp. The warp ids hold steady across all slices of a warp. In the cycle after `done`, the block is idle and `in_ready` is high.
- R11: Reset applied in the middle of a warp drops it. In the following cycle no group is valid and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer can accept an instruction |
| in_cls | input | 2 | Class code: 0 narrow, 1 special-function, 2 dual, 3 fused |
| in_warp_a | input | 5 | Identifier of the first (or only) warp |
| in_mask_a | input | 32 | Active-thread mask of the first warp |
| in_has_b | input | 1 | A second warp is offered (dual class only) |
| in_warp_b | input | 5 | Identifier of the second warp |
| in_mask_b | input | 32 | Active-thread mask of the second warp |
| slice_en | output | 32 | Lane enables, group g lane j at bit g*16+j |
| slice_tid | output | 160 | 5-bit thread index per lane, same lane order |
| grp_valid | output | 2 | Group carries a slice this cycle |
| grp_warp | output | 10 | Warp id per group, group g at bits g*5 +: 5 |
| slice_last | output | 1 | Current slice is the final one of the warp |
| done | output | 1 | Warp completes this cycle |

## Verification
The hardest case to reach from the ports is one where the mask, the lane map and the class all interact: a thread whose mask bit is clear while its lane is otherwise live. Another is group 1 sitting idle in dual class because no second warp was offered. The bench sweeps all four class codes against several mask patterns, with and without a second warp. Alternating and sparse masks put both set and clear bits under every lane in every slice. The expected enable and index of all 32 lanes are recomputed for each slice. A separate run asserts reset partway through a narrow warp to show that the remaining slices are discarded.

// File: rtl/simt_issue_pkg.sv
// Package: shared class encoding and slice-count helper for the warp
// issue sequencer. Assumes the warp size divides evenly by every lane count.
package simt_issue_pkg;

    typedef enum logic [1:0] {
        CLS_NARROW = 2'd0,
        CLS_SFU    = 2'd1,
        CLS_DUAL   = 2'd2,
        CLS_FUSED  = 2'd3
    } op_cls_e;

    // Number of slices a warp needs for a given class.
    function automatic int slice_count(op_cls_e cls, int warp, int narrow,
                                       int sfu, int grp);
        case (cls)
            CLS_NARROW: return warp / narrow;
            CLS_SFU:    return warp / sfu;
            default:    return warp / grp;
        endcase
    endfunction

endpackage

// File: rtl/simt_issue_ctrl.sv
// Control: accepts one instruction when idle, captures its fields and
// steps a slice counter until the last slice. Assumes the slice count is
// at least 2 and fits in the counter width.
module simt_issue_ctrl
    import simt_issue_pkg::*;
#(
    parameter int WARP         = 32,
    parameter int NARROW_LANES = 8,
    parameter int SFU_LANES    = 4,
    parameter int GROUP_LANES  = 16,
    parameter int WID_W        = 5,
    localparam int CNT_W       = $clog2(WARP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  op_cls_e          in_cls,
    input  logic [WID_W-1:0] in_warp_a,
    input  logic [WARP-1:0]  in_mask_a,
    input  logic             in_has_b,
    input  logic [WID_W-1:0] in_warp_b,
    input  logic [WARP-1:0]  in_mask_b,
    output logic             busy,
    output op_cls_e          cls_q,
    output logic [CNT_W-1:0] slice_q,
    output logic             last_q,
    output logic [WID_W-1:0] warp_a_q,
    output logic [WARP-1:0]  mask_a_q,
    output logic             has_b_q,
    output logic [WID_W-1:0] warp_b_q,
    output logic [WARP-1:0]  mask_b_q
);

    logic [CNT_W-1:0] last_idx_q;
    logic [CNT_W-1:0] last_idx_d;
    logic             accept;

    // Ready only when idle and out of reset.
    assign in_ready = rst_n && !busy;
    assign accept   = in_valid && in_ready;

    // Final slice index for the class being offered.
    assign last_idx_d = CNT_W'(slice_count(in_cls, WARP, NARROW_LANES,
                                           SFU_LANES, GROUP_LANES) - 1);

    assign last_q = busy && (slice_q == last_idx_q);

    // Sequencing state: busy flag and slice counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            slice_q <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            slice_q <= '0;
        end else if (busy) begin
            if (slice_q == last_idx_q) begin
                busy    <= 1'b0;
                slice_q <= '0;
            end else begin
                slice_q <= slice_q + 1'b1;
            end
        end
    end

    // Instruction capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q      <= CLS_NARROW;
            last_idx_q <= '0;
            warp_a_q   <= '0;
            mask_a_q   <= '0;
            has_b_q    <= 1'b0;
            warp_b_q   <= '0;
            mask_b_q   <= '0;
        end else if (accept) begin
            cls_q      <= in_cls;
            last_idx_q <= last_idx_d;
            warp_a_q   <= in_warp_a;
            mask_a_q   <= in_mask_a;
            has_b_q    <= in_has_b;
            warp_b_q   <= in_warp_b;
            mask_b_q   <= in_mask_b;
        end
    end

endmodule

// File: rtl/simt_lane_group.sv
// Lane group: for one 16-lane group, maps the current slice to per-lane
// thread indices and enables according to the class. GRP selects the group
// position (0 or 1). Assumes GROUP_LANES is even and at least NARROW_LANES.
module simt_lane_group
    import simt_issue_pkg::*;
#(
    parameter int GRP          = 0,
    parameter int WARP         = 32,
    parameter int NARROW_LANES = 8,
    parameter int SFU_LANES    = 4,
    parameter int GROUP_LANES  = 16,
    localparam int TID_W       = $clog2(WARP),
    localparam int HALF        = GROUP_LANES / 2
) (
    input  logic                         busy,
    input  op_cls_e                      cls,
    input  logic [TID_W-1:0]             slice,
    input  logic                         has_b,
    input  logic [WARP-1:0]              mask_a,
    input  logic [WARP-1:0]              mask_b,
    output logic                         grp_valid_o,
    output logic [GROUP_LANES-1:0]       en_o,
    output logic [GROUP_LANES*TID_W-1:0] tid_o
);

    localparam logic [TID_W-1:0] NL_T  = TID_W'(NARROW_LANES);
    localparam logic [TID_W-1:0] SL_T  = TID_W'(SFU_LANES);
    localparam logic [TID_W-1:0] GL_T  = TID_W'(GROUP_LANES);
    localparam logic [TID_W-1:0] OFS_T = TID_W'(GRP * HALF);

    // Group presence: group 0 always carries a slice; group 1 only when a
    // second warp runs in dual class or the groups are fused.
    always_comb begin
        if (GRP == 0) grp_valid_o = busy;
        else grp_valid_o = busy && ((cls == CLS_DUAL && has_b) || cls == CLS_FUSED);
    end

    for (genvar j = 0; j < GROUP_LANES; j++) begin : g_lane
        localparam logic [TID_W-1:0] J_T = TID_W'(j);
        logic             use_l;
        logic             sel_b;
        logic [TID_W-1:0] idx;

        // Per-lane occupancy and thread index for the active class.
        always_comb begin
            use_l = 1'b0;
            sel_b = 1'b0;
            idx   = '0;
            case (cls)
                CLS_NARROW: if (GRP == 0 && j < NARROW_LANES) begin
                    use_l = 1'b1;
                    idx   = slice * NL_T + J_T;
                end
                CLS_SFU: if (GRP == 0 && j < SFU_LANES) begin
                    use_l = 1'b1;
                    idx   = slice * SL_T + J_T;
                end
                CLS_DUAL: begin
                    use_l = 1'b1;
                    sel_b = (GRP != 0);
                    idx   = slice * GL_T + J_T;
                end
                CLS_FUSED: if (j < HALF) begin
                    use_l = 1'b1;
                    idx   = slice * GL_T + OFS_T + J_T;
                end
                default: use_l = 1'b0;
            endcase
            if (!grp_valid_o) begin
                use_l = 1'b0;
                idx   = '0;
            end
        end

        assign tid_o[j*TID_W +: TID_W] = idx;
        assign en_o[j] = use_l && (sel_b ? mask_b[idx] : mask_a[idx]);
    end

endmodule

// File: rtl/simt_warp_issue.sv
// Top: warp lane issue sequencer. Accepts one instruction (one or two
// warps) with a ready/valid handshake and drives one slice per cycle onto
// two lane groups until the warp is complete. Assumes two groups.
module simt_warp_issue
    import simt_issue_pkg::*;
#(
    parameter int WARP         = 32,
    parameter int NARROW_LANES = 8,
    parameter int SFU_LANES    = 4,
    parameter int GROUP_LANES  = 16,
    parameter int WID_W        = 5,
    localparam int TID_W       = $clog2(WARP),
    localparam int NGRP        = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic [1:0]                        in_cls,
    input  logic [WID_W-1:0]                  in_warp_a,
    input  logic [WARP-1:0]                   in_mask_a,
    input  logic                              in_has_b,
    input  logic [WID_W-1:0]                  in_warp_b,
    input  logic [WARP-1:0]                   in_mask_b,
    output logic [NGRP*GROUP_LANES-1:0]       slice_en,
    output logic [NGRP*GROUP_LANES*TID_W-1:0] slice_tid,
    output logic [NGRP-1:0]                   grp_valid,
    output logic [NGRP*WID_W-1:0]             grp_warp,
    output logic                              slice_last,
    output logic                              done
);

    logic             busy;
    op_cls_e          cls_q;
    logic [TID_W-1:0] slice_q;
    logic             last_q;
    logic [WID_W-1:0] warp_a_q;
    logic [WID_W-1:0] warp_b_q;
    logic [WARP-1:0]  mask_a_q;
    logic [WARP-1:0]  mask_b_q;
    logic             has_b_q;

    simt_issue_ctrl #(
        .WARP(WARP), .NARROW_LANES(NARROW_LANES), .SFU_LANES(SFU_LANES),
        .GROUP_LANES(GROUP_LANES), .WID_W(WID_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(op_cls_e'(in_cls)), .in_warp_a(in_warp_a), .in_mask_a(in_mask_a),
        .in_has_b(in_has_b), .in_warp_b(in_warp_b), .in_mask_b(in_mask_b),
        .busy(busy), .cls_q(cls_q), .slice_q(slice_q), .last_q(last_q),
        .warp_a_q(warp_a_q), .mask_a_q(mask_a_q), .has_b_q(has_b_q),
        .warp_b_q(warp_b_q), .mask_b_q(mask_b_q)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        simt_lane_group #(
            .GRP(g), .WARP(WARP), .NARROW_LANES(NARROW_LANES),
            .SFU_LANES(SFU_LANES), .GROUP_LANES(GROUP_LANES)
        ) u_grp (
            .busy(busy), .cls(cls_q), .slice(slice_q), .has_b(has_b_q),
            .mask_a(mask_a_q), .mask_b(mask_b_q),
            .grp_valid_o(grp_valid[g]),
            .en_o(slice_en[g*GROUP_LANES +: GROUP_LANES]),
            .tid_o(slice_tid[g*GROUP_LANES*TID_W +: GROUP_LANES*TID_W])
        );

        // Warp id carried by this group: its own warp in dual class, else the first.
        always_comb begin
            if (!grp_valid[g]) grp_warp[g*WID_W +: WID_W] = '0;
            else if (g != 0 && cls_q == CLS_DUAL) grp_warp[g*WID_W +: WID_W] = warp_b_q;
            else grp_warp[g*WID_W +: WID_W] = warp_a_q;
        end
    end

    assign slice_last = last_q;
    assign done       = last_q;

endmodule

// File: rtl/simt_warp_issue_chk.sv
// Checker: temporal properties on the sequencer ports, attached by bind.
module simt_warp_issue_chk #(
    parameter int WARP        = 32,
    parameter int GROUP_LANES = 16,
    parameter int WID_W       = 5,
    localparam int TID_W      = $clog2(WARP)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           in_valid,
    input logic                           in_ready,
    input logic [2*GROUP_LANES-1:0]       slice_en,
    input logic [2*GROUP_LANES*TID_W-1:0] slice_tid,
    input logic [1:0]                     grp_valid,
    input logic [2*WID_W-1:0]             grp_warp,
    input logic                           slice_last,
    input logic                           done
);

    // R2
    ready_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid[0] |-> !in_ready);

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (grp_valid[0] && !done));

    // R10
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (in_ready && !grp_valid[0]));

    // R10
    warp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid[0] && !slice_last) |=> $stable(grp_warp));

    // R6
    g1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid[1] |-> (slice_en[2*GROUP_LANES-1:GROUP_LANES] == '0));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid[0] |-> (slice_en == '0 && !done && slice_tid == '0));

    // R11
    reset_drop_chk: assert property (@(posedge clk)
        !rst_n |=> !grp_valid[0]);

endmodule

bind simt_warp_issue simt_warp_issue_chk #(
    .WARP(WARP), .GROUP_LANES(GROUP_LANES), .WID_W(WID_W)
) u_chk (.*);

// File: tb/simt_warp_issue_bench.sv
`timescale 1ns/1ps
module simt_warp_issue_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [1:0]   in_cls = 2'd0;
    logic [4:0]   in_warp_a = '0;
    logic [31:0]  in_mask_a = '0;
    logic         in_has_b = 1'b0;
    logic [4:0]   in_warp_b = '0;
    logic [31:0]  in_mask_b = '0;
    logic [31:0]  slice_en;
    logic [159:0] slice_tid;
    logic [1:0]   grp_valid;
    logic [9:0]   grp_warp;
    logic         slice_last;
    logic         done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    simt_warp_issue u_simt_warp_issue (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_warp_a(in_warp_a), .in_mask_a(in_mask_a),
        .in_has_b(in_has_b), .in_warp_b(in_warp_b), .in_mask_b(in_mask_b),
        .slice_en(slice_en), .slice_tid(slice_tid), .grp_valid(grp_valid),
        .grp_warp(grp_warp), .slice_last(slice_last), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One warp instruction, checked slice by slice.
    task automatic run_warp(input int cls, input logic [4:0] wa, input logic [31:0] ma,
                            input bit hb, input logic [4:0] wb, input logic [31:0] mb);
        int n;
        string tag;
        logic [31:0]  een;
        logic [159:0] etid;
        logic [1:0]   egv;
        logic [9:0]   ewarp;
        n   = (cls == 0) ? 4 : (cls == 1) ? 8 : 2;
        tag = (cls == 0) ? "R3" : (cls == 1) ? "R4" : (cls == 2) ? (hb ? "R5" : "R6") : "R7";
        @(negedge clk);
        chk("R2", "ready before issue", 256'(in_ready), 256'(1));
        in_valid = 1'b1; in_cls = 2'(cls); in_warp_a = wa; in_mask_a = ma;
        in_has_b = hb; in_warp_b = wb; in_mask_b = mb;
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            een = '0; etid = '0;
            for (int g = 0; g < 2; g++) begin
                for (int j = 0; j < 16; j++) begin
                    bit used;
                    int t;
                    used = 1'b0; t = 0;
                    case (cls)
                        0: begin used = (g == 0 && j < 8); t = k * 8 + j; end
                        1: begin used = (g == 0 && j < 4); t = k * 4 + j; end
                        2: begin used = (g == 0 || hb); t = k * 16 + j; end
                        default: begin used = (j < 8); t = k * 16 + g * 8 + j; end
                    endcase
                    if (used) begin
                        etid[(g*16+j)*5 +: 5] = 5'(t);
                        een[g*16+j] = (cls == 2 && g == 1) ? mb[t] : ma[t];
                    end
                end
            end
            egv   = {(cls == 3) || (cls == 2 && hb), 1'b1};
            ewarp = {egv[1] ? ((cls == 2) ? wb : wa) : 5'd0, wa};
            chk({tag, "/R8"}, $sformatf("enables slice %0d", k), 256'(slice_en), 256'(een));
            chk({tag, "/R9"}, $sformatf("thread ids slice %0d", k), 256'(slice_tid), 256'(etid));
            chk(tag, $sformatf("group valid slice %0d", k), 256'(grp_valid), 256'(egv));
            chk("R10", $sformatf("warp ids slice %0d", k), 256'(grp_warp), 256'(ewarp));
            chk("R10", $sformatf("last/done slice %0d", k), 256'({slice_last, done}),
                256'({2{k == n - 1}}));
            chk("R2", $sformatf("ready low slice %0d", k), 256'(in_ready), 256'(0));
            if (k < n - 1) @(negedge clk);
        end
        @(negedge clk);
        chk("R10", "idle after done", 256'({in_ready, grp_valid, done}), 256'({1'b1, 2'b00, 1'b0}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset state", 256'({in_ready, grp_valid, done, slice_en}),
            256'({1'b0, 2'b00, 1'b0, 32'h0}));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", 256'({in_ready, grp_valid, done, slice_en}),
            256'({1'b1, 2'b00, 1'b0, 32'h0}));
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 4; m++) begin
                for (int h = 0; h < 2; h++) begin
                    logic [31:0] ma, mb;
                    case (m)
                        0: begin ma = 32'hFFFF_FFFF; mb = 32'hFFFF_FFFF; end
                        1: begin ma = 32'hAAAA_5555; mb = 32'h5555_AAAA; end
                        2: begin ma = 32'h0000_0000; mb = 32'hF0F0_0F0F; end
                        default: begin ma = 32'h1357_9BDF; mb = 32'h8421_C3A5; end
                    endcase
                    run_warp(c, 5'(c * 8 + m * 2 + h), ma, h[0], 5'(31 - c * 4 - m), mb);
                end
            end
        end
        // R11: reset partway through a narrow warp drops it.
        @(negedge clk);
        in_valid = 1'b1; in_cls = 2'd0; in_mask_a = 32'hFFFF_FFFF; in_warp_a = 5'd9;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R11", "warp in flight before reset", 256'(grp_valid), 256'(1));
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "dropped after reset", 256'({in_ready, grp_valid, done, slice_en}),
            256'({1'b1, 2'b00, 1'b0, 32'h0}));
        run_warp(1, 5'd3, 32'hDEAD_BEEF, 1'b0, 5'd0, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule